// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block receives configuration words for an integer-N frequency synthesizer over a three-wire serial port: a serial clock, a data line and a load strobe. All three pins are brought into the system clock domain. A rising serial-clock edge shifts one data bit into a 21-bit word, most significant bit first. A rising load strobe then copies that word into one of the configuration latches. The last two bits shifted in choose the destination.

There are four destinations. The first is the reference-divider latch. The second is the feedback-divider latch, which holds the A (swallow) and B (programmable) ratios. The third is the function latch. The fourth is an initialisation write: it fills the same function latch and also sends a one-cycle reset pulse to the divider counters. The loader checks the range of the reference and B ratios. A word with an illegal ratio leaves its latch as it was and sets a sticky error flag. The serial port must run well below the system clock: each serial-clock level and each strobe level must last at least three system clock cycles.

Top module: `syn_cfg_loader`

## Requirements
- R1: After reset, every latched output is zero, including the error flag and the initialisation pulse.
- R2: Each rising serial-clock edge shifts the data pin into a 21-bit word, most significant bit first. The word is numbered w[20] (oldest bit) down to w[0] (newest bit). When more than 21 bits arrive, only the last 21 are kept.
- R3: Serial clock edges without a load-strobe rising edge leave every output unchanged.
- R4: On a load with destination code {w[1],w[0]} = 00, the outputs take these values: ref_ratio = w[15:2], ref_test = w[19:16], ld_prec = w[20].
- R5: On a load with code 01, the outputs take these values: a_ratio = w[6:2], b_ratio = w[19:7], cp_hi = w[20] (0 selects low charge-pump current, 1 selects high).
- R6: On a load with code 10, func_bits takes w[19:2] (function bit k is func_bits[k-1]) and no counter reset pulse is produced.
- R7: On a load with code 11, func_bits takes w[19:2] and cnt_init_pulse is high for exactly one system clock cycle.
- R8: A reference load whose ratio is below 3 leaves ref_ratio, ref_test and ld_prec unchanged and sets cfg_err. Ratios from 3 to 16383 are accepted.
- R9: A feedback load whose B ratio is below 3, or below its A ratio, leaves a_ratio, b_ratio and cp_hi unchanged and sets cfg_err.
- R10: Once set, cfg_err stays high until reset.
- R11: A load changes only the latch selected by its code. The other latches keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; its rising edge latches the word |
| ref_ratio | output | 14 | Reference divider ratio |
| ref_test | output | 4 | Reference-word test bits |
| ld_prec | output | 1 | Lock-detect precision select |
| a_ratio | output | 5 | Swallow counter ratio |
| b_ratio | output | 13 | Programmable counter ratio |
| cp_hi | output | 1 | Charge-pump high-current select |
| func_bits | output | 18 | Function latch contents |
| cnt_init_pulse | output | 1 | One-cycle counter reset from an initialisation write |
| cfg_err | output | 1 | Sticky flag for a rejected ratio |

## Verification
The hardest case to reach from the ports is a complete word that has been shifted in but not latched. The bench shifts a legal feedback word with the strobe held low and confirms that nothing moves. It then raises the strobe with no further clock edges and sees that same word land. A 25-bit burst checks that extra leading bits are discarded. Rejected words that sit just below legal values (reference ratio 2, B of 2, B below A) are followed by accepted words at the boundary. This shows that the rejections leave the latches untouched while the error flag stays set.

// File: rtl/syn_cfg_pkg.sv
package syn_cfg_pkg;
  localparam int WORD_W  = 21;
  localparam int CTL_W   = 2;
  localparam int PAY_W   = WORD_W - CTL_W;
  localparam int REF_W   = 14;
  localparam int TEST_W  = 4;
  localparam int A_W     = 5;
  localparam int B_W     = 13;
  localparam int FN_W    = 18;
  localparam int REF_MIN = 3;
  localparam int B_MIN   = 3;

  typedef enum logic [CTL_W-1:0] {
    DST_REF  = 2'b00,
    DST_FB   = 2'b01,
    DST_FN   = 2'b10,
    DST_INIT = 2'b11
  } dst_e;

  typedef struct packed {
    logic [REF_W-1:0]  ratio;
    logic [TEST_W-1:0] test;
    logic              prec;
  } ref_lat_t;

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           cp_hi;
  } fb_lat_t;
endpackage

// File: rtl/syn_in_sync.sv
module syn_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/syn_edge_det.sv
module syn_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/syn_shift.sv
module syn_shift #(
  parameter int W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q, word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/syn_latch_bank.sv
module syn_latch_bank
  import syn_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output ref_lat_t          ref_q,
  output fb_lat_t           fb_q,
  output logic [FN_W-1:0]   fn_q,
  output logic              init_pulse,
  output logic              err
);
  dst_e             dst;
  logic [PAY_W-1:0] pay;
  ref_lat_t         ref_new, ref_d, ref_r;
  fb_lat_t          fb_new, fb_d, fb_r;
  logic [FN_W-1:0]  fn_d, fn_r;
  logic             pulse_d, pulse_r, err_d, err_r;
  logic             ref_ok, fb_ok;

  assign dst = dst_e'(word[CTL_W-1:0]);
  assign pay = word[WORD_W-1:CTL_W];

  always_comb begin
    ref_new.ratio = pay[REF_W-1:0];
    ref_new.test  = pay[REF_W+TEST_W-1:REF_W];
    ref_new.prec  = pay[PAY_W-1];
    fb_new.a      = pay[A_W-1:0];
    fb_new.b      = pay[A_W+B_W-1:A_W];
    fb_new.cp_hi  = pay[PAY_W-1];
    ref_ok = (32'(ref_new.ratio) >= REF_MIN);
    fb_ok  = (32'(fb_new.b) >= B_MIN) && (fb_new.b >= B_W'(fb_new.a));
  end

  always_comb begin
    ref_d   = ref_r;
    fb_d    = fb_r;
    fn_d    = fn_r;
    err_d   = err_r;
    pulse_d = 1'b0;
    if (load) begin
      unique case (dst)
        DST_REF: begin
          if (ref_ok) ref_d = ref_new;
          else        err_d = 1'b1;
        end
        DST_FB: begin
          if (fb_ok) fb_d  = fb_new;
          else       err_d = 1'b1;
        end
        DST_FN: fn_d = pay[FN_W-1:0];
        DST_INIT: begin
          fn_d    = pay[FN_W-1:0];
          pulse_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_r   <= '0;
      fb_r    <= '0;
      fn_r    <= '0;
      pulse_r <= 1'b0;
      err_r   <= 1'b0;
    end else begin
      ref_r   <= ref_d;
      fb_r    <= fb_d;
      fn_r    <= fn_d;
      pulse_r <= pulse_d;
      err_r   <= err_d;
    end
  end

  assign ref_q      = ref_r;
  assign fb_q       = fb_r;
  assign fn_q       = fn_r;
  assign init_pulse = pulse_r;
  assign err        = err_r;
endmodule

// File: rtl/syn_cfg_loader.sv
module syn_cfg_loader
  import syn_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [REF_W-1:0]  ref_ratio,
  output logic [TEST_W-1:0] ref_test,
  output logic              ld_prec,
  output logic [A_W-1:0]    a_ratio,
  output logic [B_W-1:0]    b_ratio,
  output logic              cp_hi,
  output logic [FN_W-1:0]   func_bits,
  output logic              cnt_init_pulse,
  output logic              cfg_err
);
  localparam int PIN_W = 3;
  localparam int EDG_W = 2;

  logic             rst_q1, rst_q2;
  logic [PIN_W-1:0] pins_s;
  logic [EDG_W-1:0] edges;
  logic             shift_rise, le_rise;
  logic [WORD_W-1:0] word;
  ref_lat_t         ref_q;
  fb_lat_t          fb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end

  syn_in_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q2),
    .d_in   ({ser_le, ser_clk, ser_data}),
    .d_sync (pins_s)
  );

  syn_edge_det #(.W(EDG_W)) u_edge (
    .clk   (clk),
    .rst_n (rst_q2),
    .lvl   (pins_s[PIN_W-1:1]),
    .rise  (edges)
  );

  assign le_rise    = edges[1];
  assign shift_rise = edges[0];

  syn_shift #(.W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_q2),
    .shift_en (shift_rise),
    .bit_in   (pins_s[0]),
    .word     (word)
  );

  syn_latch_bank u_bank (
    .clk        (clk),
    .rst_n      (rst_q2),
    .load       (le_rise),
    .word       (word),
    .ref_q      (ref_q),
    .fb_q       (fb_q),
    .fn_q       (func_bits),
    .init_pulse (cnt_init_pulse),
    .err        (cfg_err)
  );

  assign ref_ratio = ref_q.ratio;
  assign ref_test  = ref_q.test;
  assign ld_prec   = ref_q.prec;
  assign a_ratio   = fb_q.a;
  assign b_ratio   = fb_q.b;
  assign cp_hi     = fb_q.cp_hi;
endmodule

// File: rtl/syn_cfg_chk.sv
module syn_cfg_chk
  import syn_cfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             le_rise,
  input logic [REF_W-1:0] ref_ratio,
  input logic [A_W-1:0]   a_ratio,
  input logic [B_W-1:0]   b_ratio,
  input logic [FN_W-1:0]  func_bits,
  input logic             cnt_init_pulse,
  input logic             cfg_err
);
  // R7
  init_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_init_pulse |=> !cnt_init_pulse);
  // R7
  init_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_init_pulse |-> $past(le_rise));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);
  // R8
  ref_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_ratio) |-> (32'(ref_ratio) >= REF_MIN));
  // R9
  fb_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(b_ratio) || !$stable(a_ratio)) |-> ((32'(b_ratio) >= B_MIN) && (b_ratio >= B_W'(a_ratio))));
  // R3
  fn_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(func_bits) |-> $past(le_rise));
  // R3
  ref_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_ratio) |-> $past(le_rise));
endmodule

bind syn_cfg_loader syn_cfg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .le_rise        (le_rise),
  .ref_ratio      (ref_ratio),
  .a_ratio        (a_ratio),
  .b_ratio        (b_ratio),
  .func_bits      (func_bits),
  .cnt_init_pulse (cnt_init_pulse),
  .cfg_err        (cfg_err)
);

// File: tb/syn_cfg_loader_tb.sv
module syn_cfg_loader_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [13:0] ref_ratio;
  logic [3:0]  ref_test;
  logic        ld_prec;
  logic [4:0]  a_ratio;
  logic [12:0] b_ratio;
  logic        cp_hi;
  logic [17:0] func_bits;
  logic        cnt_init_pulse;
  logic        cfg_err;

  always #4 clk = ~clk;

  syn_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio(ref_ratio), .ref_test(ref_test), .ld_prec(ld_prec),
    .a_ratio(a_ratio), .b_ratio(b_ratio), .cp_hi(cp_hi), .func_bits(func_bits),
    .cnt_init_pulse(cnt_init_pulse), .cfg_err(cfg_err)
  );

  typedef struct {
    string       tag;
    logic [13:0] rr;
    logic [3:0]  rt;
    logic        lp;
    logic [4:0]  a;
    logic [12:0] b;
    logic        cp;
    logic [17:0] fn;
    logic        err;
    int          pulses;
  } exp_t;

  exp_t q[$];
  event sample_ev;
  int checks = 0, failures = 0;
  int pulse_cnt = 0, pulse_runs = 0;
  logic pulse_prev = 1'b0;

  logic [13:0] m_rr; logic [3:0] m_rt; logic m_lp;
  logic [4:0] m_a; logic [12:0] m_b; logic m_cp;
  logic [17:0] m_fn; logic m_err; int m_pulses;

  always @(negedge clk) begin
    if (cnt_init_pulse) pulse_cnt++;
    if (cnt_init_pulse && pulse_prev) pulse_runs++;
    pulse_prev = cnt_init_pulse;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(sample_ev);
      e = q.pop_front();
      chk(e.tag, "ref_ratio", 32'(ref_ratio), 32'(e.rr));
      chk(e.tag, "ref_test",  32'(ref_test),  32'(e.rt));
      chk(e.tag, "ld_prec",   32'(ld_prec),   32'(e.lp));
      chk(e.tag, "a_ratio",   32'(a_ratio),   32'(e.a));
      chk(e.tag, "b_ratio",   32'(b_ratio),   32'(e.b));
      chk(e.tag, "cp_hi",     32'(cp_hi),     32'(e.cp));
      chk(e.tag, "func_bits", 32'(func_bits), 32'(e.fn));
      chk(e.tag, "cfg_err",   32'(cfg_err),   32'(e.err));
      chk(e.tag, "pulses",    32'(pulse_cnt), 32'(e.pulses));
    end
  end

  task automatic model_reset();
    m_rr = '0; m_rt = '0; m_lp = 1'b0; m_a = '0; m_b = '0; m_cp = 1'b0;
    m_fn = '0; m_err = 1'b0;
  endtask

  task automatic model_load(logic [20:0] w);
    case (w[1:0])
      2'b00: if (w[15:2] >= 14'd3) begin
               m_rr = w[15:2]; m_rt = w[19:16]; m_lp = w[20];
             end else m_err = 1'b1;
      2'b01: if (w[19:7] >= 13'd3 && w[19:7] >= {8'd0, w[6:2]}) begin
               m_a = w[6:2]; m_b = w[19:7]; m_cp = w[20];
             end else m_err = 1'b1;
      2'b10: m_fn = w[19:2];
      default: begin m_fn = w[19:2]; m_pulses++; end
    endcase
  endtask

  task automatic push_expect(string tag);
    exp_t e;
    e.tag = tag; e.rr = m_rr; e.rt = m_rt; e.lp = m_lp; e.a = m_a; e.b = m_b;
    e.cp = m_cp; e.fn = m_fn; e.err = m_err; e.pulses = m_pulses;
    q.push_back(e);
    @(negedge clk);
    -> sample_ev;
    @(posedge clk);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      repeat (4) @(posedge clk);
      ser_clk = 1'b1;
      repeat (4) @(posedge clk);
      ser_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
  endtask

  task automatic strobe();
    ser_le = 1'b1;
    repeat (4) @(posedge clk);
    ser_le = 1'b0;
    repeat (6) @(posedge clk);
  endtask

  task automatic write_word(logic [20:0] w, string tag);
    shift_bits({11'd0, w}, 21);
    strobe();
    model_load(w);
    push_expect(tag);
  endtask

  function automatic logic [20:0] ref_w(logic lp, logic [3:0] t, logic [13:0] r);
    return {lp, t, r, 2'b00};
  endfunction
  function automatic logic [20:0] fb_w(logic cp, logic [12:0] b, logic [4:0] a);
    return {cp, b, a, 2'b01};
  endfunction
  function automatic logic [20:0] fn_w(logic [17:0] f, logic init);
    return {1'b0, f, 1'b1, init};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : driver
    m_pulses = 0;
    model_reset();
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    push_expect("R1 reset state");
    write_word(ref_w(1'b1, 4'h0, 14'd200), "R4 reference load");
    write_word(fb_w(1'b1, 13'd1131, 5'd8), "R5 R11 feedback load");
    write_word(fn_w(18'h2A5A3, 1'b0), "R6 function load no pulse");
    write_word(fn_w(18'h00025, 1'b1), "R7 init load pulse");
    write_word(ref_w(1'b0, 4'h5, 14'd2), "R8 reference ratio 2 rejected");
    write_word(ref_w(1'b0, 4'hA, 14'd3), "R8 R10 reference ratio 3 accepted");
    write_word(ref_w(1'b1, 4'h0, 14'd16383), "R8 reference ratio max");
    write_word(fb_w(1'b0, 13'd2, 5'd0), "R9 B of 2 rejected");
    write_word(fb_w(1'b0, 13'd5, 5'd6), "R9 B below A rejected");
    write_word(fb_w(1'b0, 13'd3, 5'd3), "R9 B equal A accepted");
    // R3: a full word shifted with no strobe changes nothing
    shift_bits({11'd0, fb_w(1'b1, 13'd8191, 5'd31)}, 21);
    repeat (6) @(posedge clk);
    push_expect("R3 shift without strobe");
    strobe();
    model_load(fb_w(1'b1, 13'd8191, 5'd31));
    push_expect("R3 strobe alone latches held word");
    // R2: 25 bits, the leading four must fall off
    shift_bits({7'd0, 4'hF, ref_w(1'b0, 4'h0, 14'd1000)}, 25);
    strobe();
    model_load(ref_w(1'b0, 4'h0, 14'd1000));
    push_expect("R2 overlong burst keeps last 21");
    write_word(fn_w(18'h3FFFF, 1'b1), "R7 R11 second init load");
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    model_reset();
    push_expect("R10 R1 error cleared only by reset");
    checks++;
    if (pulse_runs != 0) begin
      failures++;
      $display("FAIL R7 pulse longer than one cycle actual=%0d expected=0", pulse_runs);
    end
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule